// File: doc/BRIEF.md
# Full-Line Write Packer

This block sits between a 128-bit AXI write master and a 256-bit AXI write slave that turns any write with incomplete byte strobes into an expensive read-modify-write. The master sends one 64-byte line as a four-beat burst. The block stores the four narrow beats and their strobes in a line buffer. It forwards nothing downstream until the whole line is present.

Once the line is complete, the block checks the strobes. If every byte lane is enabled, it issues one two-beat INCR burst at full bus width. Each downstream beat carries two master beats side by side. The slave's write response is then handed back to the master unchanged. If any strobe is missing, the block sends no downstream write and answers the master with SLVERR.

Only one transaction is in flight at a time. The block supports a single ID, and each master burst is assumed to be four 16-byte beats. Read channels and coherency attributes are not handled.

Top module: `axi_wr_line_packer`

## Requirements
- R1: After reset, m_awready is 1 and m_wready, m_bvalid, s_awvalid, s_wvalid and s_bready are all 0.
- R2: The downstream address phase carries the master address with its low 6 bits cleared, s_awlen = 1, s_awsize = 3'b101 and s_awburst = 2'b01 (INCR).
- R3: Downstream beat j carries master beat 2j in data [127:0] and strobe [15:0], and master beat 2j+1 in data [255:128] and strobe [31:16].
- R4: s_awvalid stays 0 until all four master data beats of the line have been accepted. It rises exactly two clock edges after the edge that accepts the last beat.
- R5: Every downstream data beat has all 32 strobe bits set. s_wlast is 1 on the second beat only.
- R6: If any of the 64 collected strobe bits is 0, the master receives m_bresp = 2'b10 (SLVERR) two edges after the last beat, and s_awvalid and s_wvalid stay 0 throughout.
- R7: m_bvalid rises on the edge after the s_bvalid/s_bready handshake, not before it. m_bresp equals the s_bresp value accepted there, and it holds while m_bready is low.
- R8: From the acceptance of the last master beat until the master response completes, m_wready and m_awready stay 0.
- R9: While the slave holds s_awready or s_wready low, the pending address or data beat and its valid stay unchanged.
- R10: Cycles with m_wvalid low during collection are not counted as beats. After the response, a new line starts with all strobes cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_awaddr | input | 32 | Master write address |
| m_awvalid | input | 1 | Master address valid |
| m_awready | output | 1 | Address accepted |
| m_wdata | input | 128 | Master write data |
| m_wstrb | input | 16 | Master byte strobes |
| m_wvalid | input | 1 | Master data valid |
| m_wready | output | 1 | Data accepted |
| m_bresp | output | 2 | Response to master |
| m_bvalid | output | 1 | Response valid |
| m_bready | input | 1 | Master takes response |
| s_awaddr | output | 32 | Line-aligned slave address |
| s_awlen | output | 8 | Burst length minus one |
| s_awsize | output | 3 | Beat size code |
| s_awburst | output | 2 | Burst type |
| s_awvalid | output | 1 | Slave address valid |
| s_awready | input | 1 | Slave accepts address |
| s_wdata | output | 256 | Packed write data |
| s_wstrb | output | 32 | Packed strobes |
| s_wlast | output | 1 | Last beat of burst |
| s_wvalid | output | 1 | Slave data valid |
| s_wready | input | 1 | Slave accepts data |
| s_bresp | input | 2 | Slave response |
| s_bvalid | input | 1 | Slave response valid |
| s_bready | output | 1 | Block takes slave response |

## Verification
The results arrive at fixed times, and the bench checks each one at that exact time.

- **After the last master beat:** at the following falling edge, m_wready and s_awvalid must both read 0. One falling edge later, either s_awvalid must read 1 or, for a short line, m_bvalid must read 1 with SLVERR.
- **After the slave address handshake:** the first packed beat must be on the slave port at the next falling edge.
- **After the slave response handshake:** m_bvalid must be 0 at the falling edge where s_bvalid is raised, and 1 with the copied code at the falling edge right after the handshake edge.
- **Stalls:** slave backpressure and master bubbles are inserted as whole cycles. At every stalled falling edge the bench confirms the held values are stable.

// File: rtl/wpk_pkg.sv
// Package wpk_pkg
// Shared types and constants of the full-line write packer.
// Assumes AXI response and burst encodings.
package wpk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a master address
        ST_FILL,    // collecting narrow beats
        ST_DECIDE,  // line complete, inspect strobes
        ST_ADDR,    // downstream address phase
        ST_DATA,    // downstream data phase
        ST_WAITB,   // waiting for slave response
        ST_RESP     // returning response to master
    } wpk_state_e;

    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] BURST_INCR  = 2'b01;
endpackage

// File: rtl/wpk_line_buf.sv
// Module wpk_line_buf
// Holds one line as MST_BEATS narrow beats with their strobes.
// Reports whether every strobe bit is set, and presents wide beat rd_idx
// as RATIO consecutive narrow beats, lowest beat in the low lanes.
// Assumes each slot is written at most once between clears.
module wpk_line_buf #(
    parameter int MST_DW    = 128,
    parameter int SLV_DW    = 256,
    parameter int MST_BEATS = 4,
    localparam int MST_SW   = MST_DW / 8,
    localparam int SLV_SW   = SLV_DW / 8,
    localparam int RATIO    = SLV_DW / MST_DW,
    localparam int SLV_BEATS = MST_BEATS / RATIO,
    localparam int IDX_W    = $clog2(MST_BEATS),
    localparam int RIDX_W   = (SLV_BEATS > 1) ? $clog2(SLV_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MST_DW-1:0] wr_data,
    input  logic [MST_SW-1:0] wr_strb,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [SLV_DW-1:0] rd_data,
    output logic [SLV_SW-1:0] rd_strb,
    output logic              line_full
);
    logic [MST_DW-1:0] dat_q [MST_BEATS];
    logic [MST_SW-1:0] stb_q [MST_BEATS];
    logic [MST_SW*MST_BEATS-1:0] stb_flat;

    // Strobe storage: cleared at reset and at line start, filled per beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < MST_BEATS; i++) stb_q[i] <= '0;
        end else if (wr_en) begin
            stb_q[wr_idx] <= wr_strb;
        end
    end

    // Data storage: no reset needed, strobes qualify the content.
    always_ff @(posedge clk) begin
        if (wr_en) dat_q[wr_idx] <= wr_data;
    end

    // Flatten strobes for the completeness test.
    generate
        for (genvar g = 0; g < MST_BEATS; g++) begin : g_flat
            assign stb_flat[g*MST_SW +: MST_SW] = stb_q[g];
        end
    endgenerate
    assign line_full = &stb_flat;

    // Wide beat view: RATIO narrow slots side by side.
    always_comb begin
        for (int r = 0; r < RATIO; r++) begin
            rd_data[r*MST_DW +: MST_DW] = dat_q[IDX_W'(int'(rd_idx) * RATIO + r)];
            rd_strb[r*MST_SW +: MST_SW] = stb_q[IDX_W'(int'(rd_idx) * RATIO + r)];
        end
    end

    // R10
    slot_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |-> (stb_q[wr_idx] == '0));
endmodule

// File: rtl/wpk_ctrl.sv
// Module wpk_ctrl
// Sequencer of the packer: takes one master address, counts MST_BEATS narrow
// beats, decides on strobe completeness, runs the downstream burst and
// returns the response. Assumes one outstanding transaction.
module wpk_ctrl
    import wpk_pkg::*;
#(
    parameter int MST_BEATS = 4,
    parameter int SLV_BEATS = 2,
    localparam int IDX_W    = $clog2(MST_BEATS),
    localparam int RIDX_W   = (SLV_BEATS > 1) ? $clog2(SLV_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_awvalid,
    output logic              m_awready,
    input  logic              m_wvalid,
    output logic              m_wready,
    output logic              m_bvalid,
    input  logic              m_bready,
    output logic [1:0]        m_bresp,
    input  logic              line_full,
    output logic              buf_clr,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_wr_idx,
    output logic [RIDX_W-1:0] buf_rd_idx,
    output logic              addr_load,
    output logic              s_awvalid,
    input  logic              s_awready,
    output logic              s_wvalid,
    input  logic              s_wready,
    output logic              s_wlast,
    input  logic              s_bvalid,
    output logic              s_bready,
    input  logic [1:0]        s_bresp
);
    wpk_state_e        state_q, state_d;
    logic [IDX_W-1:0]  wcnt_q;
    logic [RIDX_W-1:0] rcnt_q;
    logic [1:0]        resp_q;
    logic              last_narrow, last_wide;

    assign last_narrow = (wcnt_q == IDX_W'(MST_BEATS - 1));
    assign last_wide   = (rcnt_q == RIDX_W'(SLV_BEATS - 1));

    // Handshake outputs decoded from the state.
    assign m_awready  = (state_q == ST_IDLE);
    assign m_wready   = (state_q == ST_FILL);
    assign s_awvalid  = (state_q == ST_ADDR);
    assign s_wvalid   = (state_q == ST_DATA);
    assign s_bready   = (state_q == ST_WAITB);
    assign m_bvalid   = (state_q == ST_RESP);
    assign s_wlast    = s_wvalid && last_wide;
    assign m_bresp    = resp_q;
    assign addr_load  = m_awvalid && m_awready;
    assign buf_clr    = addr_load;
    assign buf_wr_en  = m_wvalid && m_wready;
    assign buf_wr_idx = wcnt_q;
    assign buf_rd_idx = rcnt_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (m_awvalid) state_d = ST_FILL;
            ST_FILL:   if (m_wvalid && last_narrow) state_d = ST_DECIDE;
            ST_DECIDE: state_d = line_full ? ST_ADDR : ST_RESP;
            ST_ADDR:   if (s_awready) state_d = ST_DATA;
            ST_DATA:   if (s_wready && last_wide) state_d = ST_WAITB;
            ST_WAITB:  if (s_bvalid) state_d = ST_RESP;
            ST_RESP:   if (m_bready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Narrow beat counter, advanced only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n || addr_load)  wcnt_q <= '0;
        else if (buf_wr_en)       wcnt_q <= wcnt_q + 1'b1;
    end

    // Wide beat counter for the downstream burst.
    always_ff @(posedge clk) begin
        if (!rst_n || (s_awvalid && s_awready)) rcnt_q <= '0;
        else if (s_wvalid && s_wready)          rcnt_q <= rcnt_q + 1'b1;
    end

    // Response register: error on short line, else copy of slave code.
    always_ff @(posedge clk) begin
        if (!rst_n)                                resp_q <= 2'b00;
        else if (state_q == ST_DECIDE && !line_full) resp_q <= RESP_SLVERR;
        else if (s_bvalid && s_bready)             resp_q <= s_bresp;
    end

    // R7
    mresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && !m_bready) |=> (m_bvalid && $stable(m_bresp)));
    // R7
    mresp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && s_bready) |=> (m_bvalid && m_bresp == $past(s_bresp)));
    // R8
    wready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready && last_narrow) |=> (!m_wready && !m_awready));
endmodule

// File: rtl/axi_wr_line_packer.sv
// Module axi_wr_line_packer
// Collects a full line of narrow AXI write beats, then issues it as one
// full-width, fully strobed downstream burst; short lines are answered
// with SLVERR and never reach the slave. Assumes single ID, one burst of
// MST_BEATS narrow beats per master address, one transaction at a time.
module axi_wr_line_packer
    import wpk_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int MST_DW         = 128,
    parameter int SLV_DW         = 256,
    parameter int LINE_SLV_BEATS = 2,
    localparam int MST_SW     = MST_DW / 8,
    localparam int SLV_SW     = SLV_DW / 8,
    localparam int RATIO      = SLV_DW / MST_DW,
    localparam int MST_BEATS  = LINE_SLV_BEATS * RATIO,
    localparam int LINE_BYTES = SLV_SW * LINE_SLV_BEATS,
    localparam int IDX_W      = $clog2(MST_BEATS),
    localparam int RIDX_W     = (LINE_SLV_BEATS > 1) ? $clog2(LINE_SLV_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] m_awaddr,
    input  logic              m_awvalid,
    output logic              m_awready,
    input  logic [MST_DW-1:0] m_wdata,
    input  logic [MST_SW-1:0] m_wstrb,
    input  logic              m_wvalid,
    output logic              m_wready,
    output logic [1:0]        m_bresp,
    output logic              m_bvalid,
    input  logic              m_bready,
    output logic [ADDR_W-1:0] s_awaddr,
    output logic [7:0]        s_awlen,
    output logic [2:0]        s_awsize,
    output logic [1:0]        s_awburst,
    output logic              s_awvalid,
    input  logic              s_awready,
    output logic [SLV_DW-1:0] s_wdata,
    output logic [SLV_SW-1:0] s_wstrb,
    output logic              s_wlast,
    output logic              s_wvalid,
    input  logic              s_wready,
    input  logic [1:0]        s_bresp,
    input  logic              s_bvalid,
    output logic              s_bready
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    logic              buf_clr, buf_wr_en, addr_load, line_full;
    logic [IDX_W-1:0]  buf_wr_idx;
    logic [RIDX_W-1:0] buf_rd_idx;
    logic [ADDR_W-1:0] addr_q;

    // Line-aligned address capture on master address acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (addr_load) addr_q <= m_awaddr & LINE_MASK;
    end

    assign s_awaddr  = addr_q;
    assign s_awlen   = 8'(LINE_SLV_BEATS - 1);
    assign s_awsize  = 3'($clog2(SLV_SW));
    assign s_awburst = BURST_INCR;

    wpk_line_buf #(
        .MST_DW(MST_DW), .SLV_DW(SLV_DW), .MST_BEATS(MST_BEATS)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .wr_en(buf_wr_en), .wr_idx(buf_wr_idx),
        .wr_data(m_wdata), .wr_strb(m_wstrb),
        .rd_idx(buf_rd_idx), .rd_data(s_wdata), .rd_strb(s_wstrb),
        .line_full(line_full)
    );

    wpk_ctrl #(
        .MST_BEATS(MST_BEATS), .SLV_BEATS(LINE_SLV_BEATS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .line_full(line_full), .buf_clr(buf_clr),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx),
        .buf_rd_idx(buf_rd_idx), .addr_load(addr_load),
        .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
    );

    // R4
    issue_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid |-> line_full);
    // R5
    wide_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_wvalid |-> (&s_wstrb));
    // R9
    aw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && !s_awready) |=> (s_awvalid && $stable(s_awaddr)));
    // R9
    w_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wvalid && !s_wready) |=> (s_wvalid && $stable(s_wdata) && $stable(s_wlast)));
    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bresp == RESP_SLVERR && !$past(s_bvalid)) |-> (!s_awvalid && !s_wvalid));
endmodule

// File: tb/sim_axi_wr_line_packer.sv
module sim_axi_wr_line_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  m_awaddr = '0;
    logic         m_awvalid = 1'b0;
    logic         m_awready;
    logic [127:0] m_wdata = '0;
    logic [15:0]  m_wstrb = '0;
    logic         m_wvalid = 1'b0;
    logic         m_wready;
    logic [1:0]   m_bresp;
    logic         m_bvalid;
    logic         m_bready = 1'b0;
    logic [31:0]  s_awaddr;
    logic [7:0]   s_awlen;
    logic [2:0]   s_awsize;
    logic [1:0]   s_awburst;
    logic         s_awvalid;
    logic         s_awready = 1'b0;
    logic [255:0] s_wdata;
    logic [31:0]  s_wstrb;
    logic         s_wlast;
    logic         s_wvalid;
    logic         s_wready = 1'b0;
    logic [1:0]   s_bresp = 2'b00;
    logic         s_bvalid = 1'b0;
    logic         s_bready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    axi_wr_line_packer u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] beat_val(input int seed, input int k);
        return {4{8'(seed), 8'(k), 16'h5A3C}};
    endfunction

    // Master sends one line; bad_beat >= 0 drops byte 5 of that beat.
    task automatic send_line(input int seed, input logic [31:0] addr, input int bad_beat, input int gap);
        @(negedge clk);
        m_awaddr = addr; m_awvalid = 1'b1;
        @(negedge clk);
        m_awvalid = 1'b0;
        chk(m_wready && !m_awready, "R8 fill entered", {m_wready, m_awready}, 2'b10);
        for (int k = 0; k < 4; k++) begin
            m_wvalid = 1'b0;
            repeat (gap) begin
                @(negedge clk);
                chk(!s_awvalid && m_wready, "R10 bubble", {s_awvalid, m_wready}, 2'b01);
            end
            m_wdata = beat_val(seed, k);
            m_wstrb = (k == bad_beat) ? 16'hFFDF : 16'hFFFF;
            m_wvalid = 1'b1;
            @(negedge clk);
            if (k < 3) chk(!s_awvalid, "R4 early", s_awvalid, 0);
        end
        m_wvalid = 1'b0;
        chk(!m_wready && !s_awvalid && !m_awready, "R8 held", {m_wready, s_awvalid, m_awready}, 0);
        @(negedge clk);
    endtask

    // Slave side of a full line, followed by master response.
    task automatic slave_line(input int seed, input logic [31:0] addr, input int stall,
                              input logic [1:0] code, input int bhold);
        chk(s_awvalid, "R4 issue timing", s_awvalid, 1);
        chk(s_awaddr == (addr & 32'hFFFF_FFC0), "R2 addr", s_awaddr, addr & 32'hFFFF_FFC0);
        chk(s_awlen == 8'd1 && s_awsize == 3'b101 && s_awburst == 2'b01, "R2 attrs",
            {s_awlen, s_awsize, s_awburst}, {8'd1, 3'b101, 2'b01});
        repeat (stall) begin
            @(negedge clk);
            chk(s_awvalid && s_awaddr == (addr & 32'hFFFF_FFC0), "R9 aw hold", s_awaddr, addr & 32'hFFFF_FFC0);
        end
        s_awready = 1'b1;
        @(negedge clk);
        s_awready = 1'b0;
        for (int j = 0; j < 2; j++) begin
            logic [255:0] exp_d;
            exp_d = {beat_val(seed, 2*j+1), beat_val(seed, 2*j)};
            repeat (stall) begin
                @(negedge clk);
                chk(s_wvalid && s_wdata == exp_d, "R9 w hold", s_wdata, exp_d);
            end
            chk(s_wvalid, "R3 beat present", s_wvalid, 1);
            chk(s_wdata == exp_d, "R3 packing", s_wdata, exp_d);
            chk(s_wstrb == 32'hFFFF_FFFF, "R5 strobes", s_wstrb, 32'hFFFF_FFFF);
            chk(s_wlast == (j == 1), "R5 last", s_wlast, (j == 1));
            s_wready = 1'b1;
            @(negedge clk);
            s_wready = 1'b0;
        end
        chk(s_bready && !m_bvalid, "R7 wait slave", {s_bready, m_bvalid}, 2'b10);
        s_bvalid = 1'b1; s_bresp = code;
        @(negedge clk);
        s_bvalid = 1'b0; s_bresp = 2'b00;
        chk(m_bvalid, "R7 response timing", m_bvalid, 1);
        chk(m_bresp == code, "R7 passthrough", m_bresp, code);
        repeat (bhold) begin
            @(negedge clk);
            chk(m_bvalid && m_bresp == code, "R7 hold", m_bresp, code);
        end
        m_bready = 1'b1;
        @(negedge clk);
        m_bready = 1'b0;
        chk(m_awready && !m_bvalid, "R10 back to idle", {m_awready, m_bvalid}, 2'b10);
    endtask

    task automatic t_reset;
        chk(m_awready && !m_wready && !m_bvalid && !s_awvalid && !s_wvalid && !s_bready,
            "R1 reset", {m_awready, m_wready, m_bvalid, s_awvalid, s_wvalid, s_bready}, 6'b100000);
    endtask

    task automatic t_basic;
        send_line(1, 32'h1000_0040, -1, 0);
        slave_line(1, 32'h1000_0040, 0, 2'b00, 0);
    endtask

    task automatic t_stalls;
        send_line(2, 32'h2345_6778, -1, 2);
        slave_line(2, 32'h2345_6778, 3, 2'b01, 2);
    endtask

    task automatic t_short_line;
        send_line(3, 32'h0000_0100, 2, 0);
        chk(m_bvalid && m_bresp == 2'b10, "R6 slverr", m_bresp, 2'b10);
        repeat (3) begin
            @(negedge clk);
            chk(!s_awvalid && !s_wvalid && m_bvalid, "R6 no downstream", {s_awvalid, s_wvalid, m_bvalid}, 3'b001);
        end
        m_bready = 1'b1;
        @(negedge clk);
        m_bready = 1'b0;
        chk(m_awready && !s_awvalid, "R6 idle after", {m_awready, s_awvalid}, 2'b10);
    endtask

    task automatic t_after_error;
        send_line(4, 32'h0ABC_0FC0, -1, 1);
        slave_line(4, 32'h0ABC_0FC0, 1, 2'b11, 0);
        send_line(5, 32'h0000_0000, 0, 0);
        chk(m_bvalid && m_bresp == 2'b10 && !s_awvalid, "R10 strobes cleared", m_bresp, 2'b10);
        m_bready = 1'b1;
        @(negedge clk);
        m_bready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stalls();
        t_short_line();
        t_after_error();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule